// File: doc/BRIEF.md
# Serial Port FIFO Pair with Threshold Flags

This block sits between a host register port and the byte-level shifters of a UART-style serial port. It keeps a 16-entry transmit queue and a 16-entry receive queue of 8-bit bytes. The host pushes bytes into the transmit queue and pops bytes from the receive queue through a small register map. The serial side takes bytes from the transmit queue and puts bytes into the receive queue, each with a one-cycle strobe.

Two sticky threshold flags tell software when to act. The transmit flag reports that the transmit queue has drained to its programmed low mark. The receive flag reports that the receive queue has reached its programmed high mark. Each flag is driven by a three-state machine:
- `FL_CLEAR`: the flag reads 0. It moves to `FL_PEND` when the level condition holds.
- `FL_PEND`: the flag reads 1 but has not yet been seen by software. A status read moves it to `FL_ARMED`.
- `FL_ARMED`: the flag reads 1 and has been seen. Writing 0 to its status bit moves it back to `FL_CLEAR`.

If the level condition still holds after a clear, the flag goes to `FL_PEND` on the next edge.

Register map, selected by `host_addr`:

| Address | Access | Function |
|---|---|---|
| 0 | write | transmit data |
| 1 | read | receive data; reading pops the receive queue |
| 2 | read/write | status |
| 3 | read/write | control |
| 4 | read | counts |

Reads of any other address return 0. `host_rdata` is combinational from `host_addr`. Only an asserted `host_rd` has side effects.

Top module: `fifo_trig_flags`

## Requirements
- R1: The transmit flag (status bit 0) sets when the transmit count is at or below the threshold chosen by control bits [1:0]. Codes 00, 01, 10 and 11 select 8, 4, 2 and 0 bytes. Once set, the flag stays set until software clears it.
- R2: The receive flag (status bit 1) sets when the receive count is at or above the threshold chosen by control bits [3:2]. Codes 00, 01, 10 and 11 select 1, 4, 8 and 14 bytes. Once set, the flag stays set until software clears it.
- R3: A status write with a flag's bit equal to 0 clears that flag only if a status read (`host_rd` at address 2) saw the flag as 1 beforehand. Writing 1 to a flag bit has no effect, and so does writing 0 to a flag that has not been read as 1.
- R4: If a flag is cleared while its level condition still holds, it reads 0 for exactly one cycle and then reads 1 again.
- R5: Address 4 reads the transmit count in bits [15:8] and the receive count in bits [7:0].
- R6: The transmit queue returns bytes in the order they were written. A host write to a full queue (16 bytes) is dropped. A receive push into a full queue is also dropped, and `rx_full` is high while 16 bytes are held.
- R7: A host read of the empty receive queue returns the last byte popped (0 after reset) and leaves the count at 0.
- R8: An accepted push and an accepted pop in the same cycle leave that queue's count unchanged.
- R9: After reset both counts are 0, control is 0 and both flags read 0. On the first edge after reset the transmit flag sets, because the empty transmit queue is at or below its threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops at address 1, arms flags at address 2) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 16 | Read data for the selected register |
| tx_ready | output | 1 | Transmit queue holds at least one byte |
| tx_data | output | 8 | Oldest byte in the transmit queue |
| tx_take | input | 1 | Serial side removes the oldest transmit byte |
| rx_put | input | 1 | Serial side pushes a received byte |
| rx_byte | input | 8 | Received byte |
| rx_full | output | 1 | Receive queue holds 16 bytes |

## Verification
The in-RTL assertions check these properties on every cycle:
- A met level condition with no clear pending always leaves the flag set on the next cycle.
- A zero written to a flag that was never armed does not clear it.
- A clear of an armed flag always produces one cycle at 0.
- A queue's count never moves on a dropped push, on a pop of an empty queue, or on a matched push and pop.

Some behaviours only the bench's scenarios can show, by comparing every cycle against a queue-based model:
- the threshold value each trigger code selects
- the byte ordering through both queues
- the last-value return on an empty read
- the layout of the count register

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_PEND  = 2'd1,
        FL_ARMED = 2'd2
    } flag_state_e;

    localparam logic [2:0] A_TXDATA = 3'd0;
    localparam logic [2:0] A_RXDATA = 3'd1;
    localparam logic [2:0] A_STATUS = 3'd2;
    localparam logic [2:0] A_CTRL   = 3'd3;
    localparam logic [2:0] A_COUNT  = 3'd4;

    function automatic logic [7:0] tx_threshold(input logic [1:0] code);
        unique case (code)
            2'b00:   return 8'd8;
            2'b01:   return 8'd4;
            2'b10:   return 8'd2;
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [7:0] rx_threshold(input logic [1:0] code);
        unique case (code)
            2'b00:   return 8'd1;
            2'b01:   return 8'd4;
            2'b10:   return 8'd8;
            default: return 8'd14;
        endcase
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     din_i,
    input  logic             pop_i,
    output logic [W-1:0]     dout_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             push_ok, pop_ok;

    assign full_o  = (count == CNT_W'(DEPTH));
    assign empty_o = (count == '0);
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;
    assign dout_o  = mem[rptr];
    assign count_o = count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din_i;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> $stable(count_o)); // R6
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i) |=> (count_o == '0)); // R7
    AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !full_o && !empty_o) |=> $stable(count_o)); // R8

endmodule

// File: rtl/trig_flag.sv
module trig_flag
    import fifo_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_met_i,
    input  logic stat_read_i,
    input  logic clear_req_i,
    output logic flag_o
);

    flag_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FL_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FL_CLEAR: if (level_met_i) state_nx = FL_PEND;
            FL_PEND:  if (stat_read_i) state_nx = FL_ARMED;
            FL_ARMED: if (clear_req_i) state_nx = FL_CLEAR;
            default:  state_nx = FL_CLEAR;
        endcase
    end

    assign flag_o = (state != FL_CLEAR);

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (level_met_i && !clear_req_i) |=> flag_o); // R1 R2
    AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FL_PEND && clear_req_i) |=> flag_o); // R3
    AST_CLEAR_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FL_ARMED && clear_req_i) |=> !flag_o); // R4

endmodule

// File: rtl/fifo_trig_flags.sv
module fifo_trig_flags
    import fifo_trig_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 3,
    parameter int RD_W   = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int HALF  = RD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [RD_W-1:0]   host_rdata,
    output logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_take,
    input  logic              rx_put,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              rx_full
);

    logic [3:0]        ctrl_q;
    logic [DATA_W-1:0] last_rx_q;
    logic [DATA_W-1:0] rx_head;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic [HALF-1:0]   tx_cnt_x, rx_cnt_x;
    logic              tx_full, tx_empty, rx_empty;
    logic              tx_flag, rx_flag;
    logic              tx_push, rx_pop, stat_rd, stat_wr;

    assign tx_push = host_wr && (host_addr == ADDR_W'(A_TXDATA));
    assign rx_pop  = host_rd && (host_addr == ADDR_W'(A_RXDATA));
    assign stat_rd = host_rd && (host_addr == ADDR_W'(A_STATUS));
    assign stat_wr = host_wr && (host_addr == ADDR_W'(A_STATUS));
    assign tx_cnt_x = HALF'(tx_cnt);
    assign rx_cnt_x = HALF'(rx_cnt);

    byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(tx_push), .din_i(host_wdata),
        .pop_i(tx_take), .dout_o(tx_data),
        .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
    );

    byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(rx_put), .din_i(rx_byte),
        .pop_i(rx_pop), .dout_o(rx_head),
        .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
    );

    assign tx_ready = !tx_empty;

    trig_flag i_tx_flag (
        .clk(clk), .rst_n(rst_n),
        .level_met_i(8'(tx_cnt_x) <= tx_threshold(ctrl_q[1:0])),
        .stat_read_i(stat_rd),
        .clear_req_i(stat_wr && !host_wdata[0]),
        .flag_o(tx_flag)
    );

    trig_flag i_rx_flag (
        .clk(clk), .rst_n(rst_n),
        .level_met_i(8'(rx_cnt_x) >= rx_threshold(ctrl_q[3:2])),
        .stat_read_i(stat_rd),
        .clear_req_i(stat_wr && !host_wdata[1]),
        .flag_o(rx_flag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            last_rx_q <= '0;
        end else begin
            if (host_wr && (host_addr == ADDR_W'(A_CTRL))) ctrl_q <= host_wdata[3:0];
            if (rx_pop && !rx_empty) last_rx_q <= rx_head;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            ADDR_W'(A_RXDATA): host_rdata = RD_W'(rx_empty ? last_rx_q : rx_head);
            ADDR_W'(A_STATUS): host_rdata = RD_W'({rx_flag, tx_flag});
            ADDR_W'(A_CTRL):   host_rdata = RD_W'(ctrl_q);
            ADDR_W'(A_COUNT):  host_rdata = {tx_cnt_x, rx_cnt_x};
            default:           host_rdata = '0;
        endcase
    end

    AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_push && !tx_take) |=> tx_full); // R6
    AST_RX_EMPTY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |=> (host_addr != ADDR_W'(A_RXDATA) || rx_put || !rx_empty
                                  || host_rdata == RD_W'($past(host_rdata)))); // R7

endmodule

// File: tb/test_fifo_trig_flags.sv
module test_fifo_trig_flags;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  host_addr;
    logic        host_wr, host_rd;
    logic [7:0]  host_wdata;
    logic [15:0] host_rdata;
    logic        tx_ready, tx_take, rx_put, rx_full;
    logic [7:0]  tx_data, rx_byte;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fifo_trig_flags i_fifo_trig_flags (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_take(tx_take),
        .rx_put(rx_put), .rx_byte(rx_byte), .rx_full(rx_full)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // reference model
    int txq[$];
    int rxq[$];
    int tx_st = 0, rx_st = 0;   // 0 clear, 1 set unseen, 2 set and seen
    int ctrl = 0;
    int last_rx = 0;

    function automatic int tx_thr(int c);
        case (c & 3) 0: return 8; 1: return 4; 2: return 2; default: return 0; endcase
    endfunction
    function automatic int rx_thr(int c);
        case (c & 3) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
    endfunction

    function automatic int exp_rdata(int a);
        case (a)
            1: return (rxq.size() > 0) ? rxq[0] : last_rx;
            2: return ((rx_st != 0) ? 2 : 0) | ((tx_st != 0) ? 1 : 0);
            3: return ctrl;
            4: return (txq.size() << 8) | rxq.size();
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int next_st(int st, bit cond, bit rd, bit clr);
        case (st)
            0: return cond ? 1 : 0;
            1: return rd ? 2 : 1;
            default: return clr ? 0 : 2;
        endcase
    endfunction

    // one clock: drive, compare outputs, update model at the edge
    task automatic step(input string tag, input int a, input bit wr, input bit rd,
                        input int wd, input bit take, input bit put, input int rb);
        bit tcond, rcond, srd, swr;
        host_addr = 3'(a); host_wr = wr; host_rd = rd; host_wdata = 8'(wd);
        tx_take = take; rx_put = put; rx_byte = 8'(rb);
        #1;
        chk({tag, " rdata"}, int'(host_rdata), exp_rdata(a));
        chk({tag, " tx_ready"}, int'(tx_ready), int'(txq.size() > 0));
        if (txq.size() > 0) chk({tag, " tx_data"}, int'(tx_data), txq[0]);
        chk({tag, " rx_full"}, int'(rx_full), int'(rxq.size() == 16));
        @(posedge clk);
        tcond = (txq.size() <= tx_thr(ctrl));
        rcond = (rxq.size() >= rx_thr(ctrl >> 2));
        srd = rd && a == 2;
        swr = wr && a == 2;
        tx_st = next_st(tx_st, tcond, srd, swr && !wd[0]);
        rx_st = next_st(rx_st, rcond, srd, swr && !wd[1]);
        begin
            bit tpush = wr && a == 0 && txq.size() < 16;
            bit tpop  = take && txq.size() > 0;
            bit rpop  = rd && a == 1 && rxq.size() > 0;
            bit rpush = put && rxq.size() < 16;
            if (tpop) void'(txq.pop_front());
            if (tpush) txq.push_back(wd & 8'hff);
            if (rpop) last_rx = rxq.pop_front();
            if (rpush) rxq.push_back(rb & 8'hff);
        end
        if (wr && a == 3) ctrl = wd & 4'hf;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(tag, 2, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic peek(input string tag, input int a, input int exp);
        host_addr = 3'(a); host_wr = 0; host_rd = 0; tx_take = 0; rx_put = 0;
        #1;
        chk(tag, int'(host_rdata), exp);
    endtask

    task automatic clear_flags(input string tag, input int wd);
        step(tag, 2, 0, 1, 0, 0, 0, 0);
        step(tag, 2, 1, 0, wd, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; host_addr = 0; host_wr = 0; host_rd = 0; host_wdata = 0;
        tx_take = 0; rx_put = 0; rx_byte = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset state
        peek("R9 count after reset", 4, 0);
        peek("R9 ctrl after reset", 3, 0);
        peek("R9 flags after reset", 2, 0);
        idle("R9");
        peek("R9 tx flag one edge after reset", 2, 1);

        // R5 / R1: fill tx with 10 bytes
        for (int i = 0; i < 10; i++) step("R6 tx write", 0, 1, 0, 8'h30 + i, 0, 0, 0);
        peek("R5 count layout tx", 4, 16'h0A00);
        peek("R1 sticky tx flag", 2, 1);

        // R3: zero without prior read, and writing one
        step("R3 zero unread", 2, 1, 0, 0, 0, 0, 0);
        peek("R3 unread clear ignored", 2, 1);
        step("R3 arm", 2, 0, 1, 0, 0, 0, 0);
        step("R3 write one", 2, 1, 0, 1, 0, 0, 0);
        peek("R3 write one ignored", 2, 1);
        step("R3 clear", 2, 1, 0, 0, 0, 0, 0);
        idle("R3");
        peek("R3 cleared above threshold", 2, 0);

        // R1: drain to threshold 8
        step("R1 drain", 2, 0, 0, 0, 1, 0, 0);
        step("R1 drain", 2, 0, 0, 0, 1, 0, 0);
        peek("R1 not yet set", 2, 0);
        idle("R1");
        peek("R1 set at 8", 2, 1);

        // R4: clear while condition holds
        step("R4 arm", 2, 0, 1, 0, 0, 0, 0);
        step("R4 clear", 2, 1, 0, 0, 0, 0, 0);
        peek("R4 low one cycle", 2, 0);
        idle("R4");
        peek("R4 set again", 2, 1);

        // R1: code 11 -> threshold 0
        step("R1 ctrl", 3, 1, 0, 3, 0, 0, 0);
        clear_flags("R1 clear", 0);
        for (int i = 0; i < 3; i++) idle("R1 code3 hold");
        peek("R1 code3 not set at 8", 2, 0);
        for (int i = 0; i < 8; i++) step("R6 tx order", 2, 0, 0, 0, 1, 0, 0);
        idle("R1 code3");
        peek("R1 code3 set at empty", 2, 1);

        // R6: overfill tx
        for (int i = 0; i < 17; i++) step("R6 overfill", 0, 1, 0, 8'hA0 + i, 0, 0, 0);
        peek("R6 tx full count", 4, 16'h1000);
        // R8: tx push and pop together
        step("R8 tx drop with pop", 0, 1, 0, 8'h55, 1, 0, 0);
        step("R8 tx push pop", 0, 1, 0, 8'h66, 1, 0, 0);
        peek("R8 tx count held", 4, 16'h0F00);
        for (int i = 0; i < 15; i++) step("R6 tx drain", 2, 0, 0, 0, 1, 0, 0);

        // R2: rx with code 10 -> threshold 8
        step("R2 ctrl", 3, 1, 0, 8'h08, 0, 0, 0);
        clear_flags("R2 clear", 0);
        for (int i = 0; i < 7; i++) step("R2 rx push", 2, 0, 0, 0, 0, 1, 8'hC0 + i);
        idle("R2");
        peek("R2 below threshold", 2, 1);
        step("R2 rx push", 2, 0, 0, 0, 0, 1, 8'hC7);
        idle("R2");
        peek("R2 set at 8", 2, 3);
        step("R8 rx push pop", 1, 0, 1, 0, 0, 1, 8'hC8);
        peek("R8 rx count held", 4, 8);
        for (int i = 0; i < 8; i++) step("R7 rx read", 1, 0, 1, 0, 0, 0, 0);
        peek("R7 rx empty", 4, 0);
        step("R7 empty read", 1, 0, 1, 0, 0, 0, 0);
        peek("R7 last value", 1, 8'hC8);
        peek("R7 count stays 0", 4, 0);

        // R6: overfill rx
        for (int i = 0; i < 17; i++) step("R6 rx overfill", 2, 0, 0, 0, 0, 1, 8'h10 + i);
        chk("R6 rx_full", int'(rx_full), 1);
        peek("R6 rx count", 4, 16);
        for (int i = 0; i < 16; i++) step("R6 rx order", 1, 0, 1, 0, 0, 0, 0);

        // mixed traffic across all trigger codes, compared every cycle
        for (int code = 0; code < 4; code++) begin
            step("R1 R2 ctrl", 3, 1, 0, (code << 2) | (3 - code), 0, 0, 0);
            for (int i = 0; i < 60; i++) begin
                case (i % 6)
                    0: step("R1 mix", 0, 1, 0, i, 0, 1, 200 - i);
                    1: step("R2 mix", 0, 1, 0, i + 1, (i % 12) == 7, 1, i);
                    2: step("R3 mix", 2, 0, 1, 0, 1, 0, 0);
                    3: step("R4 mix", 2, 1, 0, i & 3, 0, 1, i + 3);
                    4: step("R8 mix", 1, 0, 1, 0, 1, (i % 12) == 4, i);
                    default: step("R5 mix", 4, 0, 0, 0, code[0], 0, 0);
                endcase
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule